// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and the calendar as packed BCD values: seconds, minutes, hours (24-hour only), day of month, month, two-digit year and a weekday index. A tick-enable input, nominally pulsing at 32768 Hz, drives a prescaler. When the counter is running, every `TICKS_PER_SEC` enables advance the time by one second. Seconds carry into minutes and hours, month lengths and leap years set the day rollover, December carries into the next year, and year 99 wraps to 00.

Software uses a byte-wide register port at word-aligned byte addresses. The fields sit at 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month), 0x14 (year) and 0x18 (weekday), with control at 0x40 and status at 0x44. A busy indication is raised during the last prescaler period before each one-second update, so software can tell when an access will not race the update. The status register also holds sticky event flags for second, minute, hour and day boundaries, and software clears them by writing ones.

Software sets the time by writing the fields from year down to seconds while busy is low. Each field write takes effect at once and restarts the prescaler, so the next one-second step comes a full second after the last write.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. Control and status read 0x00 and `busy` is low.
- R2: While running, the seconds field advances by one after every `TICKS_PER_SEC` tick enables. Each field is packed BCD (tens in bits 7:4, units in bits 3:0). Seconds and minutes wrap 59→00 with a carry, and hours wrap 23→00.
- R3: At a day carry the day wraps to 01 after its month's last day (30 for months 04, 06, 09 and 11, 31 for the other months except February). The month then increments, and month 12 wraps to 01 with the year incrementing BCD and 99 wrapping to 00.
- R4: February ends at 29 when the BCD year, taken as a number 0–99, is divisible by 4 (00 included). Otherwise it ends at 28.
- R5: Control bit 0 is run. With it clear, tick enables change no field. Status bit 1 reads the run state.
- R6: Control bit 3 (12-hour select) ignores writes and always reads 0. Hours stay in 24-hour range.
- R7: Busy, seen both at the `busy` port and at status bit 0, is high only while running. It goes high from the tick enable that leaves the prescaler one enable short of a second, and it clears on the update enable. Clearing run drops it.
- R8: A write to any time field loads that field so that it reads back the new value at once. The write also restarts the prescaler, so the next step needs a full `TICKS_PER_SEC` enables.
- R9: Each one-second step sets status bit 2. A seconds carry also sets bit 3, a minutes carry also sets bit 4, and an hours carry also sets bit 5. These flags stay set until cleared.
- R10: Writing status clears each event flag whose write-data bit is 1 and leaves the others unchanged.
- R11: The weekday field (values 0–6) increments at each day carry and wraps from 6 to 0.
- R12: `rdata` is registered. It presents the register at `addr` one clock after `addr` is applied, and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per 32768 Hz oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | High during the prescaler period before an update |

## Verification
Some properties are checked on every cycle: that the seconds, hours, month and weekday registers stay within their BCD ranges, that busy never appears while stopped, that a busy window always closes on the update enable with a new seconds value, and that a stopped counter holds every field. The bench scenarios are needed for the rest. These are month-length and leap-year rollover, the carry chain into the year, the exact enable count at which busy rises, the prescaler restart on a field write, and which event flags one step sets and a write-one-to-clear removes.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
    logic [7:0] wday;
  } cal_t;

  localparam int FIELD_COUNT = 7;
  localparam int EVT_COUNT   = 4;

  // Packed BCD increment without wrap handling
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] y);
    logic [6:0] b;
    b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic run,
  input  logic restart,
  output logic step,
  output logic busy
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (restart)         cnt_q <= '0;
    else if (run && tick_en)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign busy = run && (cnt_q == LAST);
  assign step = busy && tick_en && !restart;
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import bcd_cal_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 load_en,
  input  logic [IDX_W-1:0]     load_idx,
  input  logic [7:0]           load_val,
  output cal_t                 tm,
  output logic [EVT_COUNT-1:0] evt
);
  cal_t tm_q, tm_nx;
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;

  always_comb begin
    sec_wrap  = (tm_q.sec == 8'h59);
    min_wrap  = sec_wrap  && (tm_q.min == 8'h59);
    hour_wrap = min_wrap  && (tm_q.hour == 8'h23);
    day_wrap  = hour_wrap && (tm_q.day == last_day(tm_q.mon, tm_q.year));
    mon_wrap  = day_wrap  && (tm_q.mon == 8'h12);

    tm_nx = tm_q;
    tm_nx.sec = sec_wrap ? 8'h00 : bcd_inc(tm_q.sec);
    if (sec_wrap)  tm_nx.min  = min_wrap  ? 8'h00 : bcd_inc(tm_q.min);
    if (min_wrap)  tm_nx.hour = hour_wrap ? 8'h00 : bcd_inc(tm_q.hour);
    if (hour_wrap) begin
      tm_nx.day  = day_wrap ? 8'h01 : bcd_inc(tm_q.day);
      tm_nx.wday = (tm_q.wday >= 8'h06) ? 8'h00 : tm_q.wday + 8'h01;
    end
    if (day_wrap)  tm_nx.mon  = mon_wrap ? 8'h01 : bcd_inc(tm_q.mon);
    if (mon_wrap)  tm_nx.year = (tm_q.year == 8'h99) ? 8'h00 : bcd_inc(tm_q.year);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tm_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
                mon: 8'h01, year: 8'h00, wday: 8'h00};
    end else if (load_en) begin
      case (load_idx)
        IDX_W'(0): tm_q.sec  <= load_val;
        IDX_W'(1): tm_q.min  <= load_val;
        IDX_W'(2): tm_q.hour <= load_val;
        IDX_W'(3): tm_q.day  <= load_val;
        IDX_W'(4): tm_q.mon  <= load_val;
        IDX_W'(5): tm_q.year <= load_val;
        default:   tm_q.wday <= load_val;
      endcase
    end else if (step) begin
      tm_q <= tm_nx;
    end
  end

  assign tm  = tm_q;
  assign evt = {hour_wrap, min_wrap, sec_wrap, 1'b1} & {EVT_COUNT{step}};
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import bcd_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(16);
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(17);
  localparam logic [IDX_W-1:0] NUM_FLD  = IDX_W'(FIELD_COUNT);

  logic [IDX_W-1:0]     idx;
  logic                 run_q;
  logic                 load_en, step, busy_w;
  logic [EVT_COUNT-1:0] evt_pulse, evt_q;
  cal_t                 tm_q;

  assign idx     = addr[ADDR_W-1:2];
  assign load_en = wr_en && (idx < NUM_FLD);

  cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run(run_q),
    .restart(load_en), .step(step), .busy(busy_w)
  );

  cal_time_core #(.IDX_W(3)) u_core (
    .clk(clk), .rst(rst), .step(step), .load_en(load_en),
    .load_idx(idx[2:0]), .load_val(wdata), .tm(tm_q), .evt(evt_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)                             run_q <= 1'b0;
    else if (wr_en && idx == CTRL_IDX)   run_q <= wdata[0];
  end

  for (genvar g = 0; g < EVT_COUNT; g++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst)                 evt_q[g] <= 1'b0;
      else if (evt_pulse[g])   evt_q[g] <= 1'b1;
      else if (wr_en && idx == STAT_IDX && wdata[g+2]) evt_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 8'h00;
    end else begin
      case (idx)
        IDX_W'(0): rdata <= tm_q.sec;
        IDX_W'(1): rdata <= tm_q.min;
        IDX_W'(2): rdata <= tm_q.hour;
        IDX_W'(3): rdata <= tm_q.day;
        IDX_W'(4): rdata <= tm_q.mon;
        IDX_W'(5): rdata <= tm_q.year;
        IDX_W'(6): rdata <= tm_q.wday;
        CTRL_IDX:  rdata <= {7'd0, run_q};
        STAT_IDX:  rdata <= {2'b00, evt_q, run_q, busy_w};
        default:   rdata <= 8'h00;
      endcase
    end
  end

  assign busy = busy_w;
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
  import bcd_cal_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic tick_en,
  input logic wr_en,
  input logic run,
  input logic busy,
  input cal_t tm
);
  a_r2_sec_bcd: assert property (@(posedge clk) disable iff (rst)
    (tm.sec[3:0] <= 4'd9) && (tm.sec <= 8'h59));

  a_r6_hour_24h: assert property (@(posedge clk) disable iff (rst)
    (tm.hour[3:0] <= 4'd9) && (tm.hour <= 8'h23));

  a_r3_month_range: assert property (@(posedge clk) disable iff (rst)
    (tm.mon >= 8'h01) && (tm.mon <= 8'h12));

  a_r11_wday_range: assert property (@(posedge clk) disable iff (rst)
    tm.wday <= 8'h06);

  a_r7_busy_needs_run: assert property (@(posedge clk) disable iff (rst)
    busy |-> run);

  a_r7_busy_ends_on_update: assert property (@(posedge clk) disable iff (rst)
    (busy && tick_en && !wr_en) |=> (!busy && (tm.sec != $past(tm.sec))));

  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> (tm == $past(tm)));
endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
  .run(run_q), .busy(busy), .tm(tm_q)
);

// File: tb/bcd_calendar_clock_bench.sv
module bcd_calendar_clock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;

  logic       clk, rst, tick_en, wr_en, busy;
  logic [7:0] addr, wdata, rdata;
  int checks = 0, errors = 0;

  bcd_calendar_clock #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) u_bcd_calendar_clock (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [7:0] s, m, h, d, mo, y;
    logic [7:0] xs, xm, xh, xd, xmo, xy;
    logic [7:0] xstat;
  } vec_t;

  localparam int NV = 15;
  // preset s,m,h,d,mo,y ; expected after one second ; expected status
  localparam vec_t VECS [NV] = '{
    '{8'h00,8'h00,8'h00,8'h01,8'h01,8'h00, 8'h01,8'h00,8'h00,8'h01,8'h01,8'h00, 8'h06},
    '{8'h59,8'h05,8'h00,8'h01,8'h01,8'h00, 8'h00,8'h06,8'h00,8'h01,8'h01,8'h00, 8'h0E},
    '{8'h59,8'h59,8'h09,8'h15,8'h06,8'h23, 8'h00,8'h00,8'h10,8'h15,8'h06,8'h23, 8'h1E},
    '{8'h59,8'h59,8'h23,8'h31,8'h01,8'h23, 8'h00,8'h00,8'h00,8'h01,8'h02,8'h23, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h23, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h29,8'h02,8'h24, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h24, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h30,8'h04,8'h25, 8'h00,8'h00,8'h00,8'h01,8'h05,8'h25, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h30,8'h05,8'h25, 8'h00,8'h00,8'h00,8'h31,8'h05,8'h25, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h00, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h29,8'h02,8'h00, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h10, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h10, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h28,8'h02,8'h12, 8'h00,8'h00,8'h00,8'h29,8'h02,8'h12, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h30,8'h11,8'h07, 8'h00,8'h00,8'h00,8'h01,8'h12,8'h07, 8'h3E},
    '{8'h59,8'h59,8'h23,8'h31,8'h12,8'h41, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h42, 8'h3E}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, y);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
    wr(8'h08, h); wr(8'h04, m); wr(8'h00, s);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; tick_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, v); check("R1 sec", v, 8'h00);
    rd(8'h08, v); check("R1 hour", v, 8'h00);
    rd(8'h0C, v); check("R1 day", v, 8'h01);
    rd(8'h10, v); check("R1 month", v, 8'h01);
    rd(8'h18, v); check("R1 wday", v, 8'h00);
    rd(8'h40, v); check("R1 ctrl", v, 8'h00);
    rd(8'h44, v); check("R1 status", v, 8'h00);
    check("R1 busy", {7'd0, busy}, 8'h00);
    // R12 unmapped read
    rd(8'h3C, v); check("R12 unmapped", v, 8'h00);

    // R5 stopped counter ignores ticks
    wr(8'h00, 8'h10);
    ticks(3 * TPS);
    rd(8'h00, v); check("R5 stopped sec", v, 8'h10);
    check("R5 stopped busy", {7'd0, busy}, 8'h00);
    wr(8'h40, 8'h01);
    rd(8'h44, v); check("R5 run bit", v & 8'h02, 8'h02);

    // R6 12-hour select ignored
    wr(8'h40, 8'h09);
    rd(8'h40, v); check("R6 ctrl", v, 8'h01);

    // Table: R2 carries, R3 month length, R4 leap year, R9 event flags
    for (int i = 0; i < NV; i++) begin
      set_time(VECS[i].s, VECS[i].m, VECS[i].h, VECS[i].d, VECS[i].mo, VECS[i].y);
      wr(8'h44, 8'h3C);
      ticks(TPS);
      rd(8'h00, v); check("R2 sec", v, VECS[i].xs);
      rd(8'h04, v); check("R2 min", v, VECS[i].xm);
      rd(8'h08, v); check("R2 hour", v, VECS[i].xh);
      rd(8'h0C, v); check("R3/R4 day", v, VECS[i].xd);
      rd(8'h10, v); check("R3 month", v, VECS[i].xmo);
      rd(8'h14, v); check("R3 year", v, VECS[i].xy);
      rd(8'h44, v); check("R9 status", v, VECS[i].xstat);
    end

    // R9 flags remain set across another second
    ticks(TPS);
    rd(8'h44, v); check("R9 sticky", v, 8'h3E);

    // R10 write-one-to-clear
    wr(8'h44, 8'h04);
    rd(8'h44, v); check("R10 clear sec only", v, 8'h3A);
    wr(8'h44, 8'h38);
    rd(8'h44, v); check("R10 clear rest", v, 8'h02);

    // R7 busy window
    wr(8'h00, 8'h20);
    ticks(TPS - 2);
    check("R7 busy early", {7'd0, busy}, 8'h00);
    ticks(1);
    check("R7 busy high", {7'd0, busy}, 8'h01);
    rd(8'h44, v); check("R7 status busy", v & 8'h03, 8'h03);
    ticks(1);
    check("R7 busy cleared", {7'd0, busy}, 8'h00);
    rd(8'h00, v); check("R7 update sec", v, 8'h21);
    ticks(TPS - 1);
    check("R7 busy again", {7'd0, busy}, 8'h01);
    wr(8'h40, 8'h00);
    check("R7 stop drops busy", {7'd0, busy}, 8'h00);
    wr(8'h40, 8'h01);

    // R8 field write restarts prescaler
    wr(8'h00, 8'h30);
    ticks(2);
    wr(8'h04, 8'h15);
    rd(8'h04, v); check("R8 immediate load", v, 8'h15);
    ticks(TPS - 1);
    rd(8'h00, v); check("R8 no early step", v, 8'h30);
    ticks(1);
    rd(8'h00, v); check("R8 full second", v, 8'h31);

    // R11 weekday
    wr(8'h18, 8'h06);
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h03, 8'h30);
    ticks(TPS);
    rd(8'h18, v); check("R11 wday wrap", v, 8'h00);
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h03, 8'h30);
    ticks(TPS);
    rd(8'h18, v); check("R11 wday inc", v, 8'h01);
    ticks(TPS);
    rd(8'h18, v); check("R11 wday hold", v, 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule